// File: doc/BRIEF.md
# Dual-Channel Two-Dimensional Strided DMA Engine

This block moves words between memory regions on behalf of two independent channels. Each channel sweeps a rectangle of elements: a number of elements per row and a number of rows. The source and destination addresses each have their own step within a row and their own step between rows, so the same engine can gather a sub-block of a matrix into a packed buffer, scatter a packed buffer, or transpose-like reshuffles with negative strides.

A channel is programmed through a small word-wide register port and started by a control write. In master mode the channel reads each element from its source address and writes it to its destination address. In slave mode the channel skips the read: a remote agent offers each data word on a per-channel valid/ready pair, and the channel only generates destination addresses. Both channels share one memory request port, one transfer at a time, and take turns when both have work. When a channel finishes, its interrupt line rises and stays high until software clears it.

Top module: `dma2d_dual`

## Requirements
- R1: After reset every channel's status word reads 0, every interrupt line is low and no memory request is raised.
- R2: Register selects 0 to 7 of a channel hold, in order: source base, destination base, elements per row, row count, source step within a row, source step between rows, destination step within a row, destination step between rows; each reads back what was written, the two counts truncated to 16 bits.
- R3: Select 8 is control on write (bit 0 start, bit 1 slave mode, bit 2 clear) and status on read (bit 0 busy, bit 1 slave mode, bit 2 done, bit 3 error); a start accepted on an idle channel reads busy=1 and done=0 from the next cycle and drops that channel's interrupt.
- R4: The element at row r and column c of a channel's sweep goes to destination base + r*((N-1)*inner + outer) + c*inner, with N elements per row; elements are issued row by row, column by column, modulo 2^32.
- R5: In master mode each element is one read of the matching source address followed by one write of the returned word to its destination; the number of reads equals the number of elements.
- R6: In slave mode no memory read is issued; each word accepted on that channel's slave valid/ready handshake is written, in arrival order, to the next destination address, and slave ready is never high for two channels at once.
- R7: While both channels have an element ready, grants alternate between them one transfer at a time.
- R8: A channel's interrupt rises when its last write is accepted and stays high, independent of the other channel, until a control write with the clear bit.
- R9: A start written while the channel is busy is ignored (its mode and sweep are unchanged) and sets the error bit, which stays set until a clear.
- R10: A start with zero elements per row or zero rows sets done at once, leaves busy low and makes no memory request.
- R11: A raised memory request keeps its address, write flag and write data unchanged until the cycle in which mem_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ch | input | 1 | Channel addressed by the write |
| reg_wr_sel | input | 4 | Register select of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_ch | input | 1 | Channel addressed by the read |
| reg_rd_sel | input | 4 | Register select of the read |
| reg_rd_data | output | 32 | Read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| slv_valid | input | 2 | Per-channel slave data valid |
| slv_data | input | 64 | Per-channel slave data, channel c in bits [32c+31:32c] |
| slv_ready | output | 2 | Per-channel slave data accepted |
| irq | output | 2 | Per-channel completion interrupt |

## Verification
Every cycle, the assertions hold the memory request stable until accepted, keep slave ready one-hot and never paired with a read, keep a raised interrupt up until a clear, tie a busy-time start to the error bit and only let a grant land on a requesting channel. The actual address sequences, the data carried through reads and slave beats, the strict alternation between channels, zero-count completion and the effect of a start on done can only be shown by the bench, which compares every memory write with addresses and data it derives from the closed-form row and column formula.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  parameter int ADDR_W = 32;
  parameter int CNT_W  = 16;
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_SRC     = 4'd0;
  localparam logic [SEL_W-1:0] SEL_DST     = 4'd1;
  localparam logic [SEL_W-1:0] SEL_NIN     = 4'd2;
  localparam logic [SEL_W-1:0] SEL_NOUT    = 4'd3;
  localparam logic [SEL_W-1:0] SEL_SRC_IN  = 4'd4;
  localparam logic [SEL_W-1:0] SEL_SRC_OUT = 4'd5;
  localparam logic [SEL_W-1:0] SEL_DST_IN  = 4'd6;
  localparam logic [SEL_W-1:0] SEL_DST_OUT = 4'd7;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 4'd8;

  localparam int CTL_START = 0;
  localparam int CTL_SLAVE = 1;
  localparam int CTL_CLEAR = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src_in;
    logic [ADDR_W-1:0] src_out;
    logic [ADDR_W-1:0] dst_in;
    logic [ADDR_W-1:0] dst_out;
    logic [CNT_W-1:0]  n_in;
    logic [CNT_W-1:0]  n_out;
  } geom_t;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  left_in;
    logic [CNT_W-1:0]  left_out;
    logic              last;
  } pos_t;

  typedef enum logic [1:0] {X_IDLE, X_READ, X_RWAIT, X_WRITE} xfer_st_e;

  function automatic pos_t walk_start(geom_t g);
    pos_t p;
    p.src      = g.src;
    p.dst      = g.dst;
    p.left_in  = g.n_in;
    p.left_out = g.n_out;
    p.last     = 1'b0;
    return p;
  endfunction

  // Advance one element: inner step inside a row, outer step at row end.
  function automatic pos_t walk_step(pos_t p, geom_t g);
    pos_t n;
    n      = p;
    n.last = 1'b0;
    if (p.left_in > 1) begin
      n.src     = p.src + g.src_in;
      n.dst     = p.dst + g.dst_in;
      n.left_in = p.left_in - 1'b1;
    end else if (p.left_out > 1) begin
      n.src      = p.src + g.src_out;
      n.dst      = p.dst + g.dst_out;
      n.left_in  = g.n_in;
      n.left_out = p.left_out - 1'b1;
    end else begin
      n.last = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/dma2d_chan.sv
module dma2d_chan
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              step,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              busy,
  output logic              slave,
  output logic              irq
);
  geom_t prog_q, act_q;
  pos_t  pos_q, pos_nx;
  logic  busy_q, slave_q, done_q, err_q;

  wire ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  wire start_req = ctrl_wr && wr_data[CTL_START];
  wire clr_req   = ctrl_wr && wr_data[CTL_CLEAR];
  wire start_ok  = start_req && !busy_q;
  wire empty_geo = (prog_q.n_in == '0) || (prog_q.n_out == '0);

  assign pos_nx = walk_step(pos_q, act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= '0;
      act_q   <= '0;
      pos_q   <= '0;
      busy_q  <= 1'b0;
      slave_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_SRC:     prog_q.src     <= wr_data;
          SEL_DST:     prog_q.dst     <= wr_data;
          SEL_NIN:     prog_q.n_in    <= wr_data[CNT_W-1:0];
          SEL_NOUT:    prog_q.n_out   <= wr_data[CNT_W-1:0];
          SEL_SRC_IN:  prog_q.src_in  <= wr_data;
          SEL_SRC_OUT: prog_q.src_out <= wr_data;
          SEL_DST_IN:  prog_q.dst_in  <= wr_data;
          SEL_DST_OUT: prog_q.dst_out <= wr_data;
          default: ;
        endcase
      end
      if (start_ok) begin
        act_q   <= prog_q;
        pos_q   <= walk_start(prog_q);
        slave_q <= wr_data[CTL_SLAVE];
        err_q   <= 1'b0;
        done_q  <= empty_geo;
        busy_q  <= !empty_geo;
      end else if (start_req) begin
        err_q <= 1'b1;
      end
      if (clr_req) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (step && busy_q) begin
        pos_q <= pos_nx;
        if (pos_nx.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_SRC:     rd_data = prog_q.src;
      SEL_DST:     rd_data = prog_q.dst;
      SEL_NIN:     rd_data = ADDR_W'(prog_q.n_in);
      SEL_NOUT:    rd_data = ADDR_W'(prog_q.n_out);
      SEL_SRC_IN:  rd_data = prog_q.src_in;
      SEL_SRC_OUT: rd_data = prog_q.src_out;
      SEL_DST_IN:  rd_data = prog_q.dst_in;
      SEL_DST_OUT: rd_data = prog_q.dst_out;
      SEL_CTRL:    rd_data = ADDR_W'({err_q, done_q, slave_q, busy_q});
      default:     rd_data = '0;
    endcase
  end

  assign src_addr = pos_q.src;
  assign dst_addr = pos_q.dst;
  assign busy     = busy_q;
  assign slave    = slave_q;
  assign irq      = done_q;

  assert_start_busy_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy_q) |=> (err_q && busy_q))
    else $error("start while busy did not flag error");
  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_req && !start_ok) |=> done_q)
    else $error("interrupt dropped without clear");
  assert_step_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy_q)
    else $error("step on idle channel");
endmodule

// File: rtl/dma2d_rr_arb.sv
module dma2d_rr_arb #(
  parameter int NCH = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           take,
  output logic           valid,
  output logic [IW-1:0]  idx
);
  logic [IW-1:0] last_q;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NCH; k++) begin
      int c;
      c = (int'(last_q) + k) % NCH;
      if (!valid && req[c]) begin
        valid = 1'b1;
        idx   = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(NCH - 1);
    else if (take && valid) last_q <= idx;
  end

  assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[idx])
    else $error("grant to non-requesting channel");
endmodule

// File: rtl/dma2d_dual.sv
module dma2d_dual
  import dma2d_pkg::*;
#(
  parameter int NCH = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [IW-1:0]         reg_wr_ch,
  input  logic [SEL_W-1:0]      reg_wr_sel,
  input  logic [ADDR_W-1:0]     reg_wr_data,
  input  logic [IW-1:0]         reg_rd_ch,
  input  logic [SEL_W-1:0]      reg_rd_sel,
  output logic [ADDR_W-1:0]     reg_rd_data,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [ADDR_W-1:0]     mem_wdata,
  input  logic                  mem_ready,
  input  logic                  mem_rvalid,
  input  logic [ADDR_W-1:0]     mem_rdata,
  input  logic [NCH-1:0]        slv_valid,
  input  logic [NCH*ADDR_W-1:0] slv_data,
  output logic [NCH-1:0]        slv_ready,
  output logic [NCH-1:0]        irq
);
  logic [ADDR_W-1:0] ch_src [NCH];
  logic [ADDR_W-1:0] ch_dst [NCH];
  logic [ADDR_W-1:0] ch_rd  [NCH];
  logic [NCH-1:0]    ch_busy, ch_slave, ch_step, ch_elig;

  xfer_st_e          st_q;
  logic [IW-1:0]     cur_q;
  logic [ADDR_W-1:0] buf_q;
  logic              arb_valid;
  logic [IW-1:0]     arb_idx;

  wire in_idle = (st_q == X_IDLE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2d_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en && (reg_wr_ch == IW'(c))),
      .wr_sel   (reg_wr_sel),
      .wr_data  (reg_wr_data),
      .rd_sel   (reg_rd_sel),
      .rd_data  (ch_rd[c]),
      .step     (ch_step[c]),
      .src_addr (ch_src[c]),
      .dst_addr (ch_dst[c]),
      .busy     (ch_busy[c]),
      .slave    (ch_slave[c]),
      .irq      (irq[c])
    );
    assign ch_elig[c]   = ch_busy[c] && (!ch_slave[c] || slv_valid[c]);
    assign ch_step[c]   = (st_q == X_WRITE) && mem_ready && (cur_q == IW'(c));
    assign slv_ready[c] = in_idle && arb_valid && (arb_idx == IW'(c)) && ch_slave[c];
  end

  dma2d_rr_arb #(.NCH(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ch_elig),
    .take  (in_idle),
    .valid (arb_valid),
    .idx   (arb_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= X_IDLE;
      cur_q <= '0;
      buf_q <= '0;
    end else begin
      case (st_q)
        X_IDLE: if (arb_valid) begin
          cur_q <= arb_idx;
          if (ch_slave[arb_idx]) begin
            buf_q <= slv_data[arb_idx*ADDR_W +: ADDR_W];
            st_q  <= X_WRITE;
          end else begin
            st_q  <= X_READ;
          end
        end
        X_READ:  if (mem_ready) st_q <= X_RWAIT;
        X_RWAIT: if (mem_rvalid) begin
          buf_q <= mem_rdata;
          st_q  <= X_WRITE;
        end
        X_WRITE: if (mem_ready) st_q <= X_IDLE;
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign mem_req     = (st_q == X_READ) || (st_q == X_WRITE);
  assign mem_we      = (st_q == X_WRITE);
  assign mem_addr    = (st_q == X_READ) ? ch_src[cur_q] : ch_dst[cur_q];
  assign mem_wdata   = buf_q;
  assign reg_rd_data = ch_rd[reg_rd_ch];

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
    else $error("request changed before acceptance");
  assert_slave_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == X_READ) |-> !ch_slave[cur_q])
    else $error("read issued for slave channel");
  assert_slv_ready_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_ready))
    else $error("slave ready on several channels");
  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_step) && (!(|ch_step) || mem_we))
    else $error("step without accepted write");
endmodule

// File: tb/dma2d_dual_bench.sv
module dma2d_dual_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [0:0]    reg_wr_ch = '0;
  logic [3:0]    reg_wr_sel = '0;
  logic [W-1:0]  reg_wr_data = '0;
  logic [0:0]    reg_rd_ch = '0;
  logic [3:0]    reg_rd_sel = '0;
  logic [W-1:0]  reg_rd_data;
  logic          mem_req, mem_we;
  logic [W-1:0]  mem_addr, mem_wdata;
  logic          mem_ready;
  logic          mem_rvalid;
  logic [W-1:0]  mem_rdata;
  logic [1:0]    slv_valid;
  logic [2*W-1:0] slv_data;
  logic [1:0]    slv_ready;
  logic [1:0]    irq;

  always #10 clk = ~clk;

  dma2d_dual u_dma2d_dual (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_ch(reg_wr_ch), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_ch(reg_rd_ch), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .slv_valid(slv_valid), .slv_data(slv_data), .slv_ready(slv_ready), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int n_reads = 0;
  int n_writes = 0;
  logic [W-1:0] qa0[$], qd0[$], qa1[$], qd1[$];
  int  wlog[$];
  bit  ch1_slave = 0;
  bit  slave_on = 0;
  int  slv_k = 0;
  int  slv_total = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rd_model(input logic [W-1:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [W-1:0] elem_addr(input logic [W-1:0] base, input logic [W-1:0] s_in,
      input logic [W-1:0] s_out, input int n_in, input int r, input int c);
    logic [W-1:0] row_pitch;
    row_pitch = W'(n_in - 1) * s_in + s_out;
    return base + W'(r) * row_pitch + W'(c) * s_in;
  endfunction

  function automatic logic [W-1:0] slv_word(input int k);
    return 32'hC0DE_0000 + W'(k);
  endfunction

  // Memory and slave-agent model
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready  <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      slv_valid  <= '0;
      slv_data   <= '0;
    end else begin
      mem_ready  <= ($urandom_range(0, 3) != 0);
      mem_rvalid <= 1'b0;
      if (mem_req && mem_ready && !mem_we) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd_model(mem_addr);
        n_reads++;
      end
      if (mem_req && mem_ready && mem_we) begin
        n_writes++;
        if (mem_addr[31:28] == 4'h2) begin
          wlog.push_back(1);
          if (qa1.size() == 0) chk(0, "R4", "unexpected write ch1", mem_addr, 0);
          else begin
            chk(mem_addr == qa1[0], "R4", "ch1 dst addr", mem_addr, qa1[0]);
            chk(mem_wdata == qd1[0], ch1_slave ? "R6" : "R5", "ch1 data", mem_wdata, qd1[0]);
            void'(qa1.pop_front()); void'(qd1.pop_front());
          end
        end else begin
          wlog.push_back(0);
          if (qa0.size() == 0) chk(0, "R4", "unexpected write ch0", mem_addr, 0);
          else begin
            chk(mem_addr == qa0[0], "R4", "ch0 dst addr", mem_addr, qa0[0]);
            chk(mem_wdata == qd0[0], "R5", "ch0 data", mem_wdata, qd0[0]);
            void'(qa0.pop_front()); void'(qd0.pop_front());
          end
        end
      end
      if (slv_valid[1] && slv_ready[1]) slv_k++;
      slv_valid[1] <= slave_on && (slv_k < slv_total) && ($urandom_range(0, 2) != 0);
      slv_data[2*W-1:W] <= slv_word(slv_k);
    end
  end

  task automatic finish_bench;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_bench();
  end

  task automatic wr(input int ch, input int sel, input logic [W-1:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_ch = 1'(ch); reg_wr_sel = 4'(sel); reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [W-1:0] val);
    reg_rd_ch = 1'(ch); reg_rd_sel = 4'(sel);
    #1 val = reg_rd_data;
  endtask

  task automatic setup(input int ch, input bit slave, input logic [W-1:0] src, input logic [W-1:0] dst,
      input int n_in, input int n_out, input logic [W-1:0] sis, input logic [W-1:0] sos,
      input logic [W-1:0] dis, input logic [W-1:0] dos);
    wr(ch, 0, src); wr(ch, 1, dst); wr(ch, 2, W'(n_in)); wr(ch, 3, W'(n_out));
    wr(ch, 4, sis); wr(ch, 5, sos); wr(ch, 6, dis); wr(ch, 7, dos);
    for (int r = 0; r < n_out; r++) begin
      for (int c = 0; c < n_in; c++) begin
        logic [W-1:0] a, d;
        a = elem_addr(dst, dis, dos, n_in, r, c);
        d = slave ? slv_word(r * n_in + c) : rd_model(elem_addr(src, sis, sos, n_in, r, c));
        if (ch == 0) begin qa0.push_back(a); qd0.push_back(d); end
        else begin qa1.push_back(a); qd1.push_back(d); end
      end
    end
  endtask

  task automatic wait_irq(input int ch);
    int t;
    t = 0;
    while (!irq[ch] && t < 20000) begin @(negedge clk); t++; end
    chk(irq[ch] == 1'b1, "R8", "irq after sweep", W'(irq), 0);
  endtask

  function automatic logic [W-1:0] rstride(input bit allow_neg);
    int v;
    v = allow_neg ? 4 * $urandom_range(0, 32) - 64 : 4 * $urandom_range(1, 8);
    return W'(v);
  endfunction

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(0, 8, v); chk(v == 0, "R1", "ch0 status", v, 0);
    rd(1, 8, v); chk(v == 0, "R1", "ch1 status", v, 0);
    chk(irq == 2'b00, "R1", "irq", W'(irq), 0);
    chk(mem_req == 1'b0, "R1", "mem_req", W'(mem_req), 0);

    // R2: register readback
    for (int s = 0; s < 8; s++) begin
      logic [W-1:0] val, expv;
      val  = $urandom;
      expv = (s == 2 || s == 3) ? (val & 32'h0000_FFFF) : val;
      wr(1, s, val);
      rd(1, s, v);
      chk(v == expv, "R2", "register readback", v, expv);
    end

    // R4, R5, R7, R8: dual master sweeps with random geometry
    for (int round = 0; round < 3; round++) begin
      int n0i, n0o, n1i, n1o, tot0, tot1, mn, rd0;
      n0i = $urandom_range(2, 5); n0o = $urandom_range(1, 4);
      n1i = $urandom_range(2, 5); n1o = $urandom_range(1, 4);
      tot0 = n0i * n0o; tot1 = n1i * n1o;
      ch1_slave = 0;
      setup(0, 0, 32'h0000_4000, 32'h1000_8000, n0i, n0o, rstride(0), rstride(1), rstride(0), rstride(1));
      setup(1, 0, 32'h0300_4000, 32'h2000_8000, n1i, n1o, rstride(0), rstride(1), rstride(0), rstride(1));
      wlog.delete();
      rd0 = n_reads;
      wr(0, 8, 32'h1);
      wr(1, 8, 32'h1);
      wait_irq(0); wait_irq(1);
      chk(qa0.size() == 0, "R4", "ch0 writes left", W'(qa0.size()), 0);
      chk(qa1.size() == 0, "R4", "ch1 writes left", W'(qa1.size()), 0);
      chk(n_reads - rd0 == tot0 + tot1, "R5", "read count", W'(n_reads - rd0), W'(tot0 + tot1));
      mn = (tot0 < tot1) ? tot0 : tot1;
      for (int i = 0; i < 2 * mn && i < wlog.size(); i++)
        chk(wlog[i] == i % 2, "R7", "alternating grant", W'(wlog[i]), W'(i % 2));
      repeat (5) @(negedge clk);
      chk(irq == 2'b11, "R8", "irq held", W'(irq), 3);
      rd(0, 8, v); chk(v == 32'h4, "R3", "ch0 status done", v, 32'h4);
      wr(0, 8, 32'h4);
      chk(irq == 2'b10, "R8", "clear only ch0", W'(irq), 2);
      wr(1, 8, 32'h4);
      chk(irq == 2'b00, "R8", "clear ch1", W'(irq), 0);
    end

    // R9: start while busy
    setup(0, 0, 32'h0000_6000, 32'h1000_9000, 6, 4, 32'd4, 32'd16, 32'd8, 32'hFFFF_FFC0);
    wr(0, 8, 32'h1);
    repeat (3) @(negedge clk);
    wr(0, 8, 32'h3);
    rd(0, 8, v); chk(v == 32'h9, "R9", "busy+error, mode kept", v, 32'h9);
    wait_irq(0);
    repeat (4) @(negedge clk);
    chk(qa0.size() == 0, "R9", "sweep unchanged", W'(qa0.size()), 0);
    rd(0, 8, v); chk(v == 32'hC, "R9", "done+error held", v, 32'hC);
    wr(0, 8, 32'h4);
    rd(0, 8, v); chk(v == 32'h0, "R9", "cleared", v, 0);

    // R6: slave mode on channel 1
    begin
      int rd0;
      ch1_slave = 1;
      setup(1, 1, 32'h0300_0000, 32'h2000_A000, 4, 3, 32'd4, 32'd4, 32'd12, 32'd100);
      rd0 = n_reads;
      slv_k = 0; slv_total = 12;
      wr(1, 8, 32'h3);
      slave_on = 1;
      wait_irq(1);
      slave_on = 0;
      repeat (3) @(negedge clk);
      chk(n_reads == rd0, "R6", "no reads in slave mode", W'(n_reads - rd0), 0);
      chk(slv_k == 12, "R6", "beats taken", W'(slv_k), 12);
      chk(qa1.size() == 0, "R6", "slave writes left", W'(qa1.size()), 0);
      wr(1, 8, 32'h4);
      ch1_slave = 0;
    end

    // R10: zero-count start
    begin
      int w0;
      wr(0, 2, 32'h0); wr(0, 3, 32'h3);
      w0 = n_writes;
      wr(0, 8, 32'h1);
      rd(0, 8, v); chk(v == 32'h4, "R10", "zero count done", v, 32'h4);
      chk(irq[0] == 1'b1, "R10", "zero count irq", W'(irq), 1);
      repeat (10) @(negedge clk);
      chk(n_writes == w0, "R10", "no memory traffic", W'(n_writes - w0), 0);
    end

    // R3: start with done still set
    setup(0, 0, 32'h0000_7000, 32'h1000_B000, 2, 2, 32'd4, 32'd4, 32'd4, 32'd4);
    wr(0, 8, 32'h1);
    rd(0, 8, v); chk(v == 32'h1, "R3", "start clears done", v, 32'h1);
    chk(irq[0] == 1'b0, "R3", "start drops irq", W'(irq), 0);
    wait_irq(0);
    repeat (3) @(negedge clk);
    chk(qa0.size() == 0, "R4", "short sweep done", W'(qa0.size()), 0);
    wr(0, 8, 32'h4);

    finish_bench();
  end
endmodule